// File: doc/BRIEF.md
# Line-Locked Clock Counter and Phase Detector

This block is the digital half of a clock generator that locks a pixel clock to an incoming horizontal sync. A programmable modulus counter runs on the pixel clock and fires a one-cycle comparison pulse once per line. A two-flip-flop phase-frequency detector compares that pulse with the rising edge of the incoming sync, which can first be inverted. It drives up and down pump requests to an external charge pump and oscillator, which sit outside this block. A hold input freezes the detector, for example during blanking, so that no correction is issued.

The block also regenerates a sync pulse from the comparison pulse. It delays it by a whole number of clocks (0 to 3) and provides it with its complement. The incoming sync is asynchronous to the pixel clock and passes through a synchronizer before edge detection. All inputs other than the sync are static controls. There is no streaming data path, so the block has no valid/ready handshake and no back-pressure; every pin is a plain level or a one-clock pulse.

Top module: `hlk_line_lock`

## Requirements
- R1: The effective modulus is `div_val`, raised to 100 when `div_val` is below 100. While counting, `cmp_pulse` is high for exactly one cycle, and successive pulses are exactly one modulus apart.
- R2: When `cnt_off` falls, the counter starts from 0, so the first `cmp_pulse` comes in the cycle that is modulus−1 cycles after release.
- R3: While `cnt_off` is high, the count is held at zero and neither `cmp_pulse` nor `sync_out` pulses.
- R4: The reference edge is the rising edge of `sync_in XOR sync_invert` (1 selects the falling edge of the raw input). The edge reaches the detector two clocks after it is first sampled, and the opposite edge has no effect.
- R5: When the reference edge comes first, `pump_up` is high from the cycle after the reference edge through the cycle that holds `cmp_pulse`.
- R6: When `cmp_pulse` comes first, `pump_dn` is high from the cycle after `cmp_pulse` through the cycle that holds the reference edge.
- R7: When both edges reach the detector in the same cycle, neither pump output rises.
- R8: While `hold` is high, both pump outputs are low in the following cycle, and any pending request is cleared.
- R9: `pump_up` and `pump_dn` are never high together.
- R10: `sync_out` equals `cmp_pulse` delayed by `dly_sel` clocks, with codes 0, 1, 2 and 3 giving 0, 1, 2 and 3 clocks.
- R11: `sync_out_n` is always the complement of `sync_out`.
- R12: During reset, `cmp_pulse`, `pump_up`, `pump_dn` and `sync_out` are low and `sync_out_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_val | input | 12 | Counter modulus (pixels per line), floor 100 |
| cnt_off | input | 1 | 1 stops the counter at zero |
| sync_in | input | 1 | Incoming horizontal sync, asynchronous |
| sync_invert | input | 1 | 1 uses the falling edge of `sync_in` |
| hold | input | 1 | 1 freezes the phase detector |
| dly_sel | input | 2 | Regenerated sync delay in whole clocks |
| cmp_pulse | output | 1 | Counter comparison pulse, one cycle per line |
| pump_up | output | 1 | Raise-frequency request to the charge pump |
| pump_dn | output | 1 | Lower-frequency request to the charge pump |
| sync_out | output | 1 | Delayed regenerated sync |
| sync_out_n | output | 1 | Complement of `sync_out` |

## Verification
The bench builds the block with its default parameters: a 12-bit modulus, a floor of 100, a 2-bit delay code and a two-stage synchronizer. The floor keeps each line only 100 cycles long, so every pump scenario fits in a short window. The 12-bit width still puts the largest modulus of 4095 and the values below the floor within reach. With the two-stage synchronizer, the sync edge can be placed so that it lands on, just before or just after the comparison pulse, which covers the up, down and coincidence cases. Every delay code is swept against the same pulse position.

// File: rtl/hlk_pkg.sv
package hlk_pkg;
  localparam int unsigned HLK_CNT_W   = 12;
  localparam int unsigned HLK_CNT_MIN = 100;
  localparam int unsigned HLK_DLY_W   = 2;
  localparam int unsigned HLK_META    = 2;

  typedef struct packed {
    logic up;
    logic dn;
  } pump_t;
endpackage

// File: rtl/hlk_ref_edge.sv
module hlk_ref_edge #(
  parameter int unsigned META = hlk_pkg::HLK_META
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_raw,
  input  logic invert,
  output logic ref_edge
);
  logic [META-1:0] sh_q;
  logic            last_q;

  generate
    if (META == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sync_raw ^ invert;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[META-2:0], sync_raw ^ invert};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sh_q[META-1];
  end

  assign ref_edge = sh_q[META-1] & ~last_q;

  // R4
  ref_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_edge |=> !ref_edge);
endmodule

// File: rtl/hlk_line_counter.sv
module hlk_line_counter #(
  parameter int unsigned CNT_W   = hlk_pkg::HLK_CNT_W,
  parameter int unsigned CNT_MIN = hlk_pkg::HLK_CNT_MIN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] div_val,
  input  logic             cnt_off,
  output logic             cmp_pulse
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(CNT_MIN);

  logic [CNT_W-1:0] eff;
  logic [CNT_W-1:0] term;
  logic [CNT_W-1:0] count_q;
  logic             at_term;

  always_comb begin
    eff  = (div_val < MIN_V) ? MIN_V : div_val;
    term = eff - 1'b1;
  end

  assign at_term = (count_q >= term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_q <= '0;
    else if (cnt_off) count_q <= '0;
    else if (at_term) count_q <= '0;
    else              count_q <= count_q + 1'b1;
  end

  assign cmp_pulse = at_term & ~cnt_off;

  // R3
  off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_off |=> (count_q == '0));
  // R1
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pulse |=> !cmp_pulse);
  // R1
  pulse_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pulse |=> (count_q == '0));
endmodule

// File: rtl/hlk_pfd.sv
module hlk_pfd
  import hlk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ref_edge,
  input  logic  fb_edge,
  input  logic  hold,
  output pump_t pump
);
  pump_t pump_q;
  pump_t pump_d;

  always_comb begin
    pump_d.up = pump_q.up | ref_edge;
    pump_d.dn = pump_q.dn | fb_edge;
    if (hold || (pump_d.up && pump_d.dn)) begin
      pump_d.up = 1'b0;
      pump_d.dn = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pump_q <= '0;
    else        pump_q <= pump_d;
  end

  assign pump = pump_q;

  // R9
  pump_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_q.up && pump_q.dn));
  // R8
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!pump_q.up && !pump_q.dn));
  // R7
  coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_edge && fb_edge && !pump_q.up && !pump_q.dn) |=> (!pump_q.up && !pump_q.dn));
  // R5
  up_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_q.up && !fb_edge && !hold) |=> pump_q.up);
  // R6
  dn_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_q.dn && !ref_edge && !hold) |=> pump_q.dn);
endmodule

// File: rtl/hlk_sync_delay.sv
module hlk_sync_delay #(
  parameter int unsigned DLY_W = hlk_pkg::HLK_DLY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_in,
  input  logic [DLY_W-1:0] dly_sel,
  output logic             sync_out
);
  localparam int unsigned DEPTH = (1 << DLY_W) - 1;

  logic [DEPTH:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[DEPTH:1] <= '0;
    else        stage[DEPTH:1] <= stage[DEPTH-1:0];
  end

  assign stage[0] = pulse_in;
  assign sync_out = stage[dly_sel];

  // R10
  one_clock_dly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(dly_sel) && dly_sel == DLY_W'(1)) |-> (sync_out == $past(pulse_in)));
endmodule

// File: rtl/hlk_line_lock.sv
module hlk_line_lock
  import hlk_pkg::*;
#(
  parameter int unsigned CNT_W       = HLK_CNT_W,
  parameter int unsigned CNT_MIN     = HLK_CNT_MIN,
  parameter int unsigned DLY_W       = HLK_DLY_W,
  parameter int unsigned META_STAGES = HLK_META
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] div_val,
  input  logic             cnt_off,
  input  logic             sync_in,
  input  logic             sync_invert,
  input  logic             hold,
  input  logic [DLY_W-1:0] dly_sel,
  output logic             cmp_pulse,
  output logic             pump_up,
  output logic             pump_dn,
  output logic             sync_out,
  output logic             sync_out_n
);
  logic  ref_edge;
  logic  fb_edge;
  pump_t pump;

  hlk_ref_edge #(.META(META_STAGES)) u_ref (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_raw (sync_in),
    .invert   (sync_invert),
    .ref_edge (ref_edge)
  );

  hlk_line_counter #(.CNT_W(CNT_W), .CNT_MIN(CNT_MIN)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_val   (div_val),
    .cnt_off   (cnt_off),
    .cmp_pulse (fb_edge)
  );

  hlk_pfd u_pfd (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_edge (ref_edge),
    .fb_edge  (fb_edge),
    .hold     (hold),
    .pump     (pump)
  );

  hlk_sync_delay #(.DLY_W(DLY_W)) u_dly (
    .clk      (clk),
    .rst_n    (rst_n),
    .pulse_in (fb_edge),
    .dly_sel  (dly_sel),
    .sync_out (sync_out)
  );

  assign cmp_pulse  = fb_edge;
  assign pump_up    = pump.up;
  assign pump_dn    = pump.dn;
  assign sync_out_n = ~sync_out;
endmodule

// File: tb/test_hlk_line_lock.sv
module test_hlk_line_lock;
  localparam int FLOOR = 100;
  localparam int LAT   = 2;

  typedef struct packed {
    logic        inv;
    logic        hld;
    int unsigned a;
    int unsigned exp_up;
    int unsigned exp_dn;
  } pfd_vec_t;

  // Edge driven in cycle a; reference reaches detector in a+2; comparison pulse in cycle 99.
  localparam pfd_vec_t PFD_VECS [8] = '{
    '{1'b0, 1'b0, 50,  47, 0},
    '{1'b0, 1'b0, 96,   1, 0},
    '{1'b0, 1'b0, 97,   0, 0},
    '{1'b0, 1'b0, 98,   0, 1},
    '{1'b0, 1'b0, 120,  0, 23},
    '{1'b1, 1'b0, 60,  37, 0},
    '{1'b0, 1'b1, 50,   0, 0},
    '{1'b1, 1'b1, 110,  0, 0}
  };

  localparam int DIVS [8] = '{0, 50, 99, 100, 101, 257, 1000, 4095};

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] div_val;
  logic        cnt_off;
  logic        sync_in;
  logic        sync_invert;
  logic        hold;
  logic [1:0]  dly_sel;
  logic        cmp_pulse, pump_up, pump_dn, sync_out, sync_out_n;

  int checks = 0;
  int fails  = 0;

  hlk_line_lock i_hlk_line_lock (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .cnt_off(cnt_off),
    .sync_in(sync_in), .sync_invert(sync_invert), .hold(hold), .dly_sel(dly_sel),
    .cmp_pulse(cmp_pulse), .pump_up(pump_up), .pump_dn(pump_dn),
    .sync_out(sync_out), .sync_out_n(sync_out_n)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic flush();
    @(negedge clk);
    cnt_off = 1'b1;
    hold    = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements actual=150000 expected=fewer cycles");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; div_val = 12'd100; cnt_off = 1'b0; sync_in = 1'b0;
    sync_invert = 1'b0; hold = 1'b0; dly_sel = 2'd0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(cmp_pulse == 1'b0, "R12", "cmp_pulse in reset", cmp_pulse, 0);
    check(pump_up == 1'b0,   "R12", "pump_up in reset", pump_up, 0);
    check(pump_dn == 1'b0,   "R12", "pump_dn in reset", pump_dn, 0);
    check(sync_out == 1'b0,  "R12", "sync_out in reset", sync_out, 0);
    check(sync_out_n == 1'b1,"R12", "sync_out_n in reset", sync_out_n, 1);
    rst_n = 1'b1;

    // R9 R5 R6 R7 R8 R4: table walk
    foreach (PFD_VECS[k]) begin
      int n_up, n_dn, n_both;
      flush();
      div_val = 12'd100; sync_invert = PFD_VECS[k].inv; sync_in = PFD_VECS[k].inv;
      repeat (6) @(negedge clk);
      cnt_off = 1'b0; hold = PFD_VECS[k].hld;
      n_up = 0; n_dn = 0; n_both = 0;
      for (int j = 1; j <= 150; j++) begin
        @(negedge clk);
        n_up += int'(pump_up); n_dn += int'(pump_dn); n_both += int'(pump_up & pump_dn);
        if (j == int'(PFD_VECS[k].a))     sync_in = ~PFD_VECS[k].inv;
        if (j == int'(PFD_VECS[k].a) + 5) sync_in = PFD_VECS[k].inv;
      end
      check(n_up == int'(PFD_VECS[k].exp_up), "R5/R7/R8/R4", $sformatf("vec%0d up cycles", k),
            n_up, int'(PFD_VECS[k].exp_up));
      check(n_dn == int'(PFD_VECS[k].exp_dn), "R6/R7/R8", $sformatf("vec%0d dn cycles", k),
            n_dn, int'(PFD_VECS[k].exp_dn));
      check(n_both == 0, "R9", $sformatf("vec%0d both high", k), n_both, 0);
    end

    // R8 hold raised while an up request is pending
    begin
      int n_up, n_dn;
      flush();
      sync_invert = 1'b0; sync_in = 1'b0;
      repeat (6) @(negedge clk);
      cnt_off = 1'b0; hold = 1'b0; n_up = 0; n_dn = 0;
      for (int j = 1; j <= 150; j++) begin
        @(negedge clk);
        n_up += int'(pump_up); n_dn += int'(pump_dn);
        if (j == 50) sync_in = 1'b1;
        if (j == 55) sync_in = 1'b0;
        if (j == 70) hold = 1'b1;
      end
      check(n_up == 18, "R8", "up cut by hold", n_up, 18);
      check(n_dn == 0,  "R8", "dn under hold", n_dn, 0);
    end

    // R1 R2 modulus and first pulse after release
    foreach (DIVS[k]) begin
      int eff, first, second, highs;
      eff = (DIVS[k] < FLOOR) ? FLOOR : DIVS[k];
      flush();
      div_val = 12'(DIVS[k]);
      @(negedge clk);
      cnt_off = 1'b0;
      first = -1; second = -1; highs = 0;
      for (int j = 1; j <= 2 * eff; j++) begin
        @(negedge clk);
        if (cmp_pulse) begin
          highs++;
          if (first < 0) first = j; else if (second < 0) second = j;
        end
      end
      check(first == eff - 1, "R2", $sformatf("first pulse div=%0d", DIVS[k]), first, eff - 1);
      check(second - first == eff, "R1", $sformatf("period div=%0d", DIVS[k]), second - first, eff);
      check(highs == 2, "R1", $sformatf("pulse cycles div=%0d", DIVS[k]), highs, 2);
    end

    // R3 counter off
    begin
      int n_cmp, n_sync;
      flush();
      div_val = 12'd100; dly_sel = 2'd0; n_cmp = 0; n_sync = 0;
      for (int j = 0; j < 300; j++) begin
        @(negedge clk);
        n_cmp += int'(cmp_pulse); n_sync += int'(sync_out);
      end
      check(n_cmp == 0,  "R3", "cmp_pulse while off", n_cmp, 0);
      check(n_sync == 0, "R3", "sync_out while off", n_sync, 0);
    end

    // R10 R11 delay codes
    for (int d = 0; d < 4; d++) begin
      int first, highs, bad_n;
      flush();
      dly_sel = 2'(d);
      repeat (6) @(negedge clk);
      cnt_off = 1'b0; first = -1; highs = 0; bad_n = 0;
      for (int j = 1; j <= 150; j++) begin
        @(negedge clk);
        if (sync_out) begin highs++; if (first < 0) first = j; end
        if (sync_out_n !== ~sync_out) bad_n++;
      end
      check(first == 99 + d, "R10", $sformatf("sync_out cycle code=%0d", d), first, 99 + d);
      check(highs == 1, "R10", $sformatf("sync_out width code=%0d", d), highs, 1);
      check(bad_n == 0, "R11", $sformatf("complement code=%0d", d), bad_n, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule